// File: doc/BRIEF.md
# Sample Packer and Capture Controller

This block sits between a stream of complex samples and a 64-bit-wide FIFO. It reduces each sample to one of four stored formats: the real part alone or the full complex pair, each at 16-bit or 32-bit precision. It packs the results into 64-bit words, writes them to the FIFO, and gives them back to a reader as a sequence of 16-bit register reads.

A small capture state machine decides which samples are stored. After an arm, a trigger that arrives together with a valid sample fixes the trigger sample. A programmable post-trigger count moves the first stored sample later. A programmable pretrigger count moves it earlier, drawing on a short history ring. In block mode a set number of samples is stored, the last partial word is flushed, and the block stops until it is armed again. In continuous mode storage goes on until the FIFO cannot take a word. Capture then halts, and it needs an empty FIFO, a rearm and a new trigger before it resumes.

Top module: `capture_packer`

## Requirements
- R1: The format is chosen by cfg_cplx and cfg_wide. With {cfg_cplx,cfg_wide}=00 each sample stores smp_re[31:16] as a 16-bit chunk, four to a word. With 01 it stores smp_re as a 32-bit chunk, two to a word. With 10 it stores {smp_im[31:16],smp_re[31:16]} as a 32-bit chunk, two to a word. With 11 it stores {smp_im,smp_re}, one to a word. The earliest sample in a word occupies the least significant chunk.
- R2: With cfg_cont=0, exactly cfg_len samples (cfg_len at least 1) are stored. A final partial word is written at once with its unused upper chunks zero, and st_done is raised. Triggers that follow write nothing until the block is armed again.
- R3: With cfg_cont=1, capture continues without limit and only complete words are written. Reads may be made while capture is running.
- R4: If a word completes while fifo_full is high, the word is dropped, capture stops and st_ovf is raised. An arm is ignored while the FIFO still holds data. Once the FIFO is empty, an arm rearms the block.
- R5: For a trigger on sample k with post-trigger count N, the first stored sample is k+1+N.
- R6: With pretrigger count P (0 to 15), the first stored sample is k+1+N-P. A trigger is ignored until P valid samples have arrived since the arm.
- R7: A read request returns one 16-bit part of the oldest word, least significant part first, with rd_valid high on the cycle after the request. fifo_rd is pulsed on the first of the four reads.
- R8: Out of reset, all four status flags are low. At most one of st_armed, st_capt, st_done and st_ovf is high at any time. st_capt covers both the post-trigger wait and storage.
- R9: An arm takes effect only when the block is idle, done, or in overflow with an empty FIFO. An arm during capture is ignored.
- R10: A cycle with smp_vld low stores nothing and advances no count, and a trigger on such a cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cont | input | 1 | 1 = continuous capture, 0 = block capture |
| cfg_cplx | input | 1 | 1 = store complex pair, 0 = real part only |
| cfg_wide | input | 1 | 1 = 32-bit precision, 0 = 16-bit precision |
| cfg_len | input | LEN_W | Block length in samples |
| cfg_post | input | POST_W | Post-trigger offset in samples |
| cfg_pre | input | log2(PRE_DEPTH) | Pretrigger offset in samples |
| arm | input | 1 | Arm request pulse |
| trig | input | 1 | Trigger, qualified by smp_vld |
| smp_vld | input | 1 | Sample valid |
| smp_re | input | SMP_W | Real component |
| smp_im | input | SMP_W | Imaginary component |
| fifo_full | input | 1 | FIFO cannot accept a word |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 2*SMP_W | Packed word |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rdata | input | 2*SMP_W | Head word of FIFO, shown before it is popped |
| fifo_rd | output | 1 | FIFO pop strobe |
| rd_req | input | 1 | Register read request |
| rd_data | output | RD_W | Read data |
| rd_valid | output | 1 | rd_data holds a fresh part |
| st_armed | output | 1 | Waiting for a trigger |
| st_capt | output | 1 | Post-trigger wait or storing |
| st_done | output | 1 | Block complete |
| st_ovf | output | 1 | Stopped by overflow |

## Verification
The overflow path is the hardest to reach. It needs continuous mode, a FIFO that is already full and a word completing at that moment. Then the rearm must be refused until the last of four part-reads of the last word has drained the FIFO. The bench models a shallow FIFO and streams several words beyond its depth without reading. It tries an arm while data remain, then reads everything out and checks that the stored words continue the expected sample sequence with no gap. Pretrigger cases draw random offsets with gaps in the stream, so the history ring is read at many different distances.

// File: rtl/capture_packer.sv
module capture_packer #(
  parameter int SMP_W     = 32,
  parameter int LEN_W     = 16,
  parameter int POST_W    = 26,
  parameter int PRE_DEPTH = 16,
  parameter int RD_W      = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_cont,
  input  logic                         cfg_cplx,
  input  logic                         cfg_wide,
  input  logic [LEN_W-1:0]             cfg_len,
  input  logic [POST_W-1:0]            cfg_post,
  input  logic [$clog2(PRE_DEPTH)-1:0] cfg_pre,
  input  logic                         arm,
  input  logic                         trig,
  input  logic                         smp_vld,
  input  logic [SMP_W-1:0]             smp_re,
  input  logic [SMP_W-1:0]             smp_im,
  input  logic                         fifo_full,
  output logic                         fifo_wr,
  output logic [2*SMP_W-1:0]           fifo_wdata,
  input  logic                         fifo_empty,
  input  logic [2*SMP_W-1:0]           fifo_rdata,
  output logic                         fifo_rd,
  input  logic                         rd_req,
  output logic [RD_W-1:0]              rd_data,
  output logic                         rd_valid,
  output logic                         st_armed,
  output logic                         st_capt,
  output logic                         st_done,
  output logic                         st_ovf
);
  localparam int WORD_W = 2 * SMP_W;
  localparam int HALF   = SMP_W / 2;
  localparam int PRE_W  = $clog2(PRE_DEPTH);
  localparam int SL_W   = $clog2(WORD_W / HALF);
  localparam int NRD    = WORD_W / RD_W;
  localparam int PH_W   = $clog2(NRD);
  localparam logic [PRE_W-1:0] PF_MAX = PRE_W'(PRE_DEPTH - 1);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_DLY, S_CAP, S_DONE, S_OVF} st_t;

  st_t                st;
  logic [WORD_W-1:0]  ring [PRE_DEPTH];
  logic [PRE_W-1:0]   wp, pf;
  logic [POST_W-1:0]  post_cnt;
  logic [LEN_W-1:0]   cnt;
  logic [SL_W-1:0]    slot, slot_last;
  logic [WORD_W-1:0]  acc, chunk, packed_w, hold;
  logic [PH_W-1:0]    ph;
  int                 shamt;

  wire [PRE_W-1:0]  rp   = wp - cfg_pre;
  wire [WORD_W-1:0] dly  = (cfg_pre == '0) ? {smp_im, smp_re} : ring[rp];
  wire [SMP_W-1:0]  d_re = dly[SMP_W-1:0];
  wire [SMP_W-1:0]  d_im = dly[WORD_W-1:SMP_W];

  wire in_cap   = (st == S_CAP) || (st == S_DLY && post_cnt == '0);
  wire take     = smp_vld && in_cap;
  wire last     = !cfg_cont && (cnt == cfg_len - LEN_W'(1));
  wire word_end = take && (slot == slot_last || last);
  wire rd_idle  = (ph == '0);
  wire arm_ok   = arm && (st == S_IDLE || st == S_DONE ||
                          (st == S_OVF && fifo_empty && rd_idle));

  always_comb begin
    chunk = '0;
    shamt = 0;
    slot_last = '0;
    unique case ({cfg_cplx, cfg_wide})
      2'b00: begin
        chunk = WORD_W'(d_re[SMP_W-1:HALF]);
        slot_last = SL_W'(WORD_W / HALF - 1);
        shamt = int'(slot) * HALF;
      end
      2'b01: begin
        chunk = WORD_W'(d_re);
        slot_last = SL_W'(WORD_W / SMP_W - 1);
        shamt = int'(slot) * SMP_W;
      end
      2'b10: begin
        chunk = WORD_W'({d_im[SMP_W-1:HALF], d_re[SMP_W-1:HALF]});
        slot_last = SL_W'(WORD_W / SMP_W - 1);
        shamt = int'(slot) * SMP_W;
      end
      default: begin
        chunk = {d_im, d_re};
        slot_last = '0;
        shamt = 0;
      end
    endcase
  end

  assign packed_w   = acc | (chunk << shamt);
  assign fifo_wr    = word_end && !fifo_full;
  assign fifo_wdata = packed_w;

  always_ff @(posedge clk)
    if (smp_vld) ring[wp] <= {smp_im, smp_re};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      wp <= '0;
      pf <= '0;
      post_cnt <= '0;
      cnt <= '0;
      slot <= '0;
      acc <= '0;
    end else begin
      if (smp_vld) wp <= wp + PRE_W'(1);
      if (arm_ok) begin
        st <= S_ARM;
        pf <= '0;
        cnt <= '0;
        slot <= '0;
        acc <= '0;
      end else begin
        unique case (st)
          S_ARM: begin
            if (smp_vld && trig && pf >= cfg_pre) begin
              st <= S_DLY;
              post_cnt <= cfg_post;
            end else if (smp_vld && pf != PF_MAX) begin
              pf <= pf + PRE_W'(1);
            end
          end
          S_DLY: if (smp_vld && post_cnt != '0) post_cnt <= post_cnt - POST_W'(1);
          default: ;
        endcase
      end
      if (take) begin
        cnt <= cnt + LEN_W'(1);
        if (word_end) begin
          acc <= '0;
          slot <= '0;
        end else begin
          acc <= packed_w;
          slot <= slot + SL_W'(1);
        end
        if (word_end && fifo_full) st <= S_OVF;
        else if (last)             st <= S_DONE;
        else                       st <= S_CAP;
      end
    end
  end

  assign fifo_rd = rd_req && rd_idle && !fifo_empty;
  wire [RD_W-1:0] rd_slice = RD_W'(hold >> (int'(ph) * RD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0;
      hold <= '0;
      rd_data <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (fifo_rd) begin
        hold <= fifo_rdata;
        rd_data <= fifo_rdata[RD_W-1:0];
        ph <= PH_W'(1);
        rd_valid <= 1'b1;
      end else if (rd_req && !rd_idle) begin
        rd_data <= rd_slice;
        ph <= ph + PH_W'(1);
        rd_valid <= 1'b1;
      end
    end
  end

  assign st_armed = (st == S_ARM);
  assign st_capt  = (st == S_DLY) || (st == S_CAP);
  assign st_done  = (st == S_DONE);
  assign st_ovf   = (st == S_OVF);

  // R4
  ovf_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ovf) |-> $past(fifo_full));
  // R2
  done_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> $past(fifo_wr));
  // R7
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req));
  // R7
  first_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fifo_rd) |-> rd_data == $past(fifo_rdata[RD_W-1:0]));
  // R8
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_armed, st_capt, st_done, st_ovf}));
  // R9
  arm_in_capt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_capt && arm) |=> !st_armed);
endmodule

// File: tb/capture_packer_tb.sv
module capture_packer_tb_top;
  localparam int CLK_P = 10;
  localparam int FD    = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_cont = 0, cfg_cplx = 0, cfg_wide = 0;
  logic [15:0] cfg_len = 1;
  logic [25:0] cfg_post = 0;
  logic [3:0]  cfg_pre = 0;
  logic arm = 0, trig = 0, smp_vld = 0, rd_req = 0;
  logic [31:0] smp_re = 0, smp_im = 0;
  logic fifo_full = 0, fifo_empty = 1;
  logic [63:0] fifo_rdata = 0;
  logic fifo_wr, fifo_rd, rd_valid;
  logic [63:0] fifo_wdata;
  logic [15:0] rd_data;
  logic st_armed, st_capt, st_done, st_ovf;

  logic [63:0] q[$];
  logic [31:0] hre [8192];
  logic [31:0] him [8192];
  int nsent = 0, n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  capture_packer dut_i (
    .clk, .rst_n, .cfg_cont, .cfg_cplx, .cfg_wide, .cfg_len, .cfg_post, .cfg_pre,
    .arm, .trig, .smp_vld, .smp_re, .smp_im, .fifo_full, .fifo_wr, .fifo_wdata,
    .fifo_empty, .fifo_rdata, .fifo_rd, .rd_req, .rd_data, .rd_valid,
    .st_armed, .st_capt, .st_done, .st_ovf);

  always @(posedge clk) begin
    if (fifo_wr) q.push_back(fifo_wdata);
    if (fifo_rd && q.size() > 0) void'(q.pop_front());
    fifo_full  <= (q.size() >= FD);
    fifo_empty <= (q.size() == 0);
    fifo_rdata <= (q.size() > 0) ? q[0] : 64'h0;
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    finish_run();
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int spw_of(bit c, bit w);
    return (!c && !w) ? 4 : (c && w) ? 1 : 2;
  endfunction

  function automatic logic [63:0] chunk_of(int i, bit c, bit w);
    case ({c, w})
      2'b00:   return {48'h0, hre[i][31:16]};
      2'b01:   return {32'h0, hre[i]};
      2'b10:   return {32'h0, him[i][31:16], hre[i][31:16]};
      default: return {him[i], hre[i]};
    endcase
  endfunction

  function automatic logic [63:0] exp_word(int first, int widx, int nlim, bit c, bit w);
    int spw = spw_of(c, w);
    int cb = 64 / spw;
    logic [63:0] r = '0;
    for (int s = 0; s < spw; s++) begin
      int idx = widx * spw + s;
      if (nlim < 0 || idx < nlim) r |= chunk_of(first + idx, c, w) << (s * cb);
    end
    return r;
  endfunction

  task automatic pulse_arm();
    arm = 1; @(negedge clk); arm = 0;
  endtask

  task automatic send_smp(input bit t);
    if ($urandom % 4 == 0) begin
      smp_vld = 0; smp_re = $urandom; smp_im = $urandom; trig = $urandom % 2;  // R10 gap
      @(negedge clk);
    end
    smp_vld = 1; smp_re = $urandom; smp_im = $urandom; trig = t;
    hre[nsent] = smp_re; him[nsent] = smp_im; nsent++;
    @(negedge clk);
    smp_vld = 0; trig = 0;
  endtask

  task automatic read_word(input logic [63:0] exp, input string tag);
    logic [63:0] got = '0;
    bit okv = 1;
    for (int j = 0; j < 4; j++) begin
      rd_req = 1; @(negedge clk); rd_req = 0;
      if (!rd_valid) okv = 0;
      got[j*16 +: 16] = rd_data;
    end
    chk(okv && got == exp, tag, got, exp);
  endtask

  task automatic run_block(input bit c, input bit w, input int P, input int N, input int L);
    int k, f, nw, spw;
    spw = spw_of(c, w);
    cfg_cont = 0; cfg_cplx = c; cfg_wide = w;
    cfg_pre = 4'(P); cfg_post = 26'(N); cfg_len = 16'(L);
    pulse_arm();
    chk(st_armed, "R9 arm from idle/done", {63'h0, st_armed}, 64'h1);
    for (int i = 0; i < P + int'($urandom % 3); i++) send_smp(0);
    k = nsent;
    send_smp(1);
    f = k + 1 + N - P;
    if (N >= 3) begin
      send_smp(0); send_smp(0);
      pulse_arm();
      chk(st_capt && !st_armed, "R9 arm during capture ignored", {62'h0, st_capt, st_armed}, 64'h2);
      for (int i = 2; i < N + L; i++) send_smp(0);
    end else begin
      for (int i = 0; i < N + L; i++) send_smp(0);
    end
    nw = (L + spw - 1) / spw;
    chk(st_done, "R2 block done", {63'h0, st_done}, 64'h1);
    chk(q.size() == nw, "R2 word count with flush", 64'(q.size()), 64'(nw));
    for (int i = 0; i < nw; i++)
      read_word(exp_word(f, i, L, c, w), "R1 R5 R6 R7 packed word");
    send_smp(1); send_smp(1);
    chk(st_done && q.size() == 0, "R2 trigger after done ignored", 64'(q.size()), 64'h0);
  endtask

  initial begin
    int c, w, spw, k, f, rdn, stored;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({st_armed, st_capt, st_done, st_ovf, fifo_wr, rd_valid} == 6'b0, "R8 reset state",
        {58'h0, st_armed, st_capt, st_done, st_ovf, fifo_wr, rd_valid}, 64'h0);

    for (int i = 0; i < 20; i++) send_smp(0);

    for (int fm = 0; fm < 4; fm++)
      run_block(fm[1], fm[0], 0, 0, 2 * spw_of(fm[1], fm[0]) + 1);

    cfg_pre = 4'd5; cfg_post = 0; cfg_cont = 0;
    pulse_arm();
    smp_vld = 1; trig = 1; smp_re = $urandom; smp_im = $urandom;
    hre[nsent] = smp_re; him[nsent] = smp_im; nsent++;
    @(negedge clk); smp_vld = 0; trig = 0;
    chk(st_armed && !st_capt, "R6 early trigger ignored", {62'h0, st_armed, st_capt}, 64'h2);
    run_block(1, 0, 5, 4, 7);
    run_block(0, 1, 2, 200, 3);

    for (int it = 0; it < 16; it++) begin
      c = $urandom % 2; w = $urandom % 2; spw = spw_of(c[0], w[0]);
      run_block(c[0], w[0], $urandom % 16, $urandom % 12, 1 + $urandom % (spw * 5));
    end

    c = $urandom % 2; w = $urandom % 2; spw = spw_of(c[0], w[0]);
    cfg_cont = 1; cfg_cplx = c[0]; cfg_wide = w[0]; cfg_pre = 0; cfg_post = 0;
    pulse_arm();
    k = nsent; send_smp(1); f = k + 1;
    for (int i = 0; i < 3 * spw + 1; i++) send_smp(0);
    stored = 3 * spw + 1;
    chk(st_capt && q.size() == 3, "R3 only whole words", 64'(q.size()), 64'h3);
    rdn = 0;
    for (int i = 0; i < 3; i++) begin
      read_word(exp_word(f, rdn, -1, c[0], w[0]), "R3 R7 continuous word");
      rdn++;
    end
    for (int i = 0; i < (FD + 3) * spw; i++) send_smp(0);
    chk(st_ovf && !st_capt, "R4 overflow stops capture", {62'h0, st_ovf, st_capt}, 64'h2);
    chk(q.size() == FD, "R4 fifo holds depth", 64'(q.size()), 64'(FD));
    pulse_arm();
    chk(st_ovf && !st_armed, "R4 arm ignored with data left", {62'h0, st_ovf, st_armed}, 64'h2);
    for (int i = 0; i < FD; i++) begin
      read_word(exp_word(f, rdn, -1, c[0], w[0]), "R4 words before overflow");
      rdn++;
    end
    @(negedge clk);
    pulse_arm();
    chk(st_armed && !st_ovf, "R4 rearm after drain", {62'h0, st_armed, st_ovf}, 64'h2);
    if (stored < 0) n_bad++;

    run_block(1, 1, 3, 1, 4);
    finish_run();
  end
endmodule